// File: doc/BRIEF.md
# T1 Line Error Toggle Counter Bank

This block sits behind a T1 receiver's error detectors. It turns their one-cycle error pulses into a small set of status bits that a serial status word can carry. Bipolar violations, framing-bit errors, CRC errors and controlled slips of the elastic buffer each have their own counter. The block does not expose a full binary count. It reports each event class as bits that change state at fixed event counts, or as a short count that wraps.

A downstream reader samples the status bits from time to time. It infers activity by seeing which bits changed since its last look. The framing-error bit has a rate limit: it may change at most once per 768 receive frames, which is 96 ms at 125 us per frame. Framing errors that arrive during that quiet period still accumulate. Once the quiet period ends, they can produce one deferred change of the bit.

Top module: `line_err_toggles`

## Requirements
- R1: Outside a lockout, `ferr_tgl` inverts on the clock after the edge at which the number of framing errors counted since the previous inversion (or since reset) reaches 4.
- R2: After every inversion of `ferr_tgl`, a lockout holds it steady until 768 `frame_tick` pulses have been seen. A tick in the same cycle as the inversion is not counted.
- R3: Framing errors keep accruing during the lockout, saturating at 4. When the lockout ends with 4 accrued, `ferr_tgl` inverts on the next clock and a new lockout begins. Errors beyond 4 are discarded.
- R4: A 9-bit counter of `bpv_evt` pulses wraps freely. `bpv_t64`, `bpv_t128` and `bpv_t256` are its bits 6, 7 and 8, so they invert every 64, 128 and 256 violations respectively.
- R5: `crc_cnt` is a 3-bit count of `crc_evt` pulses. It wraps from 7 to 0. It advances only while `esf_mode` is 1, and `crc_evt` has no effect while `esf_mode` is 0.
- R6: `slip_tgl` inverts once for each `slip_evt` pulse.
- R7: Events of different types arriving in the same cycle are all counted in that cycle.
- R8: While `rst_n` is low, all counters, the lockout and every status bit are zero.
- R9: `status_byte` is {`ferr_tgl`, `slip_tgl`, `bpv_t256`, `bpv_t128`, `bpv_t64`, `crc_cnt[2:0]`}, from bit 7 down to bit 0. Every output is registered and reflects an event one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One pulse per 125 us receive frame |
| esf_mode | input | 1 | 1 enables CRC error counting |
| bpv_evt | input | 1 | Bipolar violation pulse |
| ferr_evt | input | 1 | Framing bit error pulse |
| crc_evt | input | 1 | CRC error pulse |
| slip_evt | input | 1 | Controlled slip pulse |
| bpv_t64 | output | 1 | Inverts every 64 violations |
| bpv_t128 | output | 1 | Inverts every 128 violations |
| bpv_t256 | output | 1 | Inverts every 256 violations |
| ferr_tgl | output | 1 | Rate-limited framing error toggle |
| slip_tgl | output | 1 | Slip toggle |
| crc_cnt | output | 3 | Wrapping CRC error count |
| status_byte | output | 8 | Packed status bits |

## Verification
Each counter's state is visible at the ports. A bad CRC or slip update therefore shows on `status_byte` one clock later. A bad bipolar count stays hidden until the next 64-event boundary, so the bench drives past 256 violations. A wrong framing accumulator or lockout length may stay invisible for up to 768 frames. The bench therefore runs full lockout windows, both with errors pending and with too few pending, and compares every cycle.

// File: rtl/line_err_toggles.sv
module line_err_toggles #(
  parameter int BPV_W       = 9,
  parameter int CRC_W       = 3,
  parameter int FERR_THRESH = 4,
  parameter int LOCK_FRAMES = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             esf_mode,
  input  logic             bpv_evt,
  input  logic             ferr_evt,
  input  logic             crc_evt,
  input  logic             slip_evt,
  output logic             bpv_t64,
  output logic             bpv_t128,
  output logic             bpv_t256,
  output logic             ferr_tgl,
  output logic             slip_tgl,
  output logic [CRC_W-1:0] crc_cnt,
  output logic [7:0]       status_byte
);

  localparam int AW = $clog2(FERR_THRESH + 1);
  localparam int LW = $clog2(LOCK_FRAMES + 1);
  localparam logic [AW-1:0] THR  = AW'(FERR_THRESH);
  localparam logic [LW-1:0] LOCK = LW'(LOCK_FRAMES);

  logic [BPV_W-1:0] bpv_q;
  logic [AW-1:0]    acc_q, acc_nxt;
  logic [LW-1:0]    lock_q;
  logic             fire;

  assign acc_nxt = (ferr_evt && acc_q < THR) ? acc_q + 1'b1 : acc_q;
  assign fire    = (lock_q == '0) && (acc_nxt >= THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpv_q    <= '0;
      crc_cnt  <= '0;
      slip_tgl <= 1'b0;
      ferr_tgl <= 1'b0;
      acc_q    <= '0;
      lock_q   <= '0;
    end else begin
      if (bpv_evt)             bpv_q    <= bpv_q + 1'b1;
      if (crc_evt && esf_mode) crc_cnt  <= crc_cnt + 1'b1;
      if (slip_evt)            slip_tgl <= ~slip_tgl;
      if (fire) begin
        ferr_tgl <= ~ferr_tgl;
        acc_q    <= '0;
        lock_q   <= LOCK;
      end else begin
        acc_q <= acc_nxt;
        if (frame_tick && lock_q != '0) lock_q <= lock_q - 1'b1;
      end
    end
  end

  assign bpv_t64  = bpv_q[BPV_W-3];
  assign bpv_t128 = bpv_q[BPV_W-2];
  assign bpv_t256 = bpv_q[BPV_W-1];
  assign status_byte = {ferr_tgl, slip_tgl, bpv_t256, bpv_t128, bpv_t64, crc_cnt[2:0]};

  // spacing monitor for the framing toggle
  logic          prev_ftgl;
  logic [LW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ftgl <= 1'b0;
      gap_q     <= LOCK;
    end else begin
      prev_ftgl <= ferr_tgl;
      if (ferr_tgl != prev_ftgl) gap_q <= frame_tick ? LW'(1) : '0;
      else if (frame_tick && gap_q < LOCK) gap_q <= gap_q + 1'b1;
    end
  end

  assert_ferr_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_tgl != prev_ftgl) |-> (gap_q >= LOCK));

  assert_slip_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> (slip_tgl != $past(slip_tgl)));

  assert_crc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |=> $stable(crc_cnt));

  assert_bpv_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bpv_evt |=> ($stable(bpv_t64) && $stable(bpv_t128) && $stable(bpv_t256)));

  assert_ferr_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ferr_evt && lock_q != '0) |=> $stable(ferr_tgl));

endmodule

// File: tb/line_err_toggles_test.sv
module line_err_toggles_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 0, esf_mode = 0, bpv_evt = 0, ferr_evt = 0, crc_evt = 0, slip_evt = 0;
  logic bpv_t64, bpv_t128, bpv_t256, ferr_tgl, slip_tgl;
  logic [2:0] crc_cnt;
  logic [7:0] status_byte;

  always #4 clk = ~clk;

  line_err_toggles uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .esf_mode(esf_mode),
    .bpv_evt(bpv_evt), .ferr_evt(ferr_evt), .crc_evt(crc_evt), .slip_evt(slip_evt),
    .bpv_t64(bpv_t64), .bpv_t128(bpv_t128), .bpv_t256(bpv_t256),
    .ferr_tgl(ferr_tgl), .slip_tgl(slip_tgl), .crc_cnt(crc_cnt), .status_byte(status_byte));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] e_b;

  logic [8:0]  m_bpv = 0;
  logic [2:0]  m_crc = 0, m_acc = 0;
  logic        m_slip = 0, m_ft = 0;
  int          m_lock = 0;

  function automatic logic [7:0] model_byte();
    return {m_ft, m_slip, m_bpv[8], m_bpv[7], m_bpv[6], m_crc};
  endfunction

  task automatic model_reset();
    m_bpv = 0; m_crc = 0; m_acc = 0; m_slip = 0; m_ft = 0; m_lock = 0;
  endtask

  task automatic step(input logic b, f, c, s, t, e);
    logic [2:0] an;
    @(negedge clk);
    bpv_evt = b; ferr_evt = f; crc_evt = c; slip_evt = s; frame_tick = t; esf_mode = e;
    @(posedge clk); #1;
    m_bpv = m_bpv + 9'(b);
    if (c && e) m_crc = m_crc + 3'd1;
    if (s) m_slip = ~m_slip;
    an = (f && m_acc < 4) ? m_acc + 3'd1 : m_acc;
    if (m_lock == 0 && an >= 4) begin m_ft = ~m_ft; m_acc = 0; m_lock = 768; end
    else begin m_acc = an; if (t && m_lock != 0) m_lock--; end
    exp_q.push_back(model_byte());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bpv_evt = 0; ferr_evt = 0; crc_evt = 0; slip_evt = 0; frame_tick = 0;
    repeat (2) @(posedge clk);
    #1; model_reset();
    exp_q.push_back(8'h00);  // R8 reset state
    @(negedge clk); rst_n = 1;
  endtask

  task automatic errs(input int k);
    for (int i = 0; i < k; i++) step(0, 1, 0, 0, 0, 0);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      e_b = exp_q.pop_front();
      n_cmp++;
      if (status_byte !== e_b) begin
        n_bad++;
        if (status_byte[7] !== e_b[7])
          $display("FAIL R1/R2/R3 ferr_tgl got %b exp %b", status_byte[7], e_b[7]);
        if (status_byte[6] !== e_b[6])
          $display("FAIL R6 slip_tgl got %b exp %b", status_byte[6], e_b[6]);
        if (status_byte[5:3] !== e_b[5:3])
          $display("FAIL R4 bpv toggles got %b exp %b", status_byte[5:3], e_b[5:3]);
        if (status_byte[2:0] !== e_b[2:0])
          $display("FAIL R5 crc_cnt got %0d exp %0d", status_byte[2:0], e_b[2:0]);
        if (status_byte[7:3] === e_b[7:3] && status_byte[2:0] === e_b[2:0])
          $display("FAIL R9 status_byte got %h exp %h", status_byte, e_b);
      end
      if ({ferr_tgl, slip_tgl, bpv_t256, bpv_t128, bpv_t64, crc_cnt} !== status_byte) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 packing got %h exp %h", {ferr_tgl, slip_tgl, bpv_t256, bpv_t128, bpv_t64, crc_cnt}, status_byte);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();                                      // R8
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 0);   // R4 past 64/128/256
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, 1);    // R5 wrap 7->0
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0);     // R5 ignored outside ESF
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);     // R6
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, 1);     // R7 all at once (4th ferr -> R1)
    do_reset();                                      // R8 after activity
    errs(3);                                         // R1 below threshold
    errs(1);                                         // R1 fourth error toggles
    errs(6);                                         // R3 accrue during lockout
    frames(767);                                     // R2 still locked
    frames(2);                                       // R3 pending toggle after expiry
    errs(2);
    frames(770);                                     // R3 too few pending: no toggle
    errs(2);                                         // R1 reaches 4 outside lockout
    errs(4);                                         // R2 locked again
    frames(3);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule